// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A single holding register sits in front of a frame shift register, so software can queue the next character while the current one is still leaving the line. The frame layout (5 to 8 data bits, optional even or odd parity, one or two stop bits) is chosen through static configuration inputs. An external baud tick paces every bit. Baud generation lives outside the block.

A transmit-done flag reports that the line has gone quiet, meaning the last frame is out and nothing is queued. This lets a half-duplex driver turn the bus around. The flag can raise an interrupt request, and it is cleared either by a write-one strobe or by the interrupt acknowledge. Dropping the enable does not cut a frame short. The transmitter drains the shifter and the holding register first, and only then releases the line driver.

Top module: `sertx_top`

## Requirements
- R1: A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then the stop bit(s) at high level. Each bit lasts from one baud tick to the next. `len_sel` values 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. The line is high whenever no frame is in progress.
- R2: With `par_en`=1, one parity bit follows the last data bit. With `par_odd`=0 the number of ones over the data and parity bits is even. With `par_odd`=1 that number is odd. With `par_en`=0 no parity bit is sent.
- R3: `two_stop`=0 sends one stop bit. `two_stop`=1 sends two stop bits.
- R4: A `wr_data` pulse while `tx_en`=1 and `buf_empty`=1 stores `wdata`, and `buf_empty` reads 0 from the next cycle. A write while the buffer is full, or while `tx_en`=0, is ignored and leaves the stored character unchanged.
- R5: On a baud tick where the shifter is free (idle, or finishing its last stop bit) and the buffer is full, the character moves into the shifter. `buf_empty` returns to 1 and the start bit appears after that same clock edge, so frames follow each other with no idle gap.
- R6: `txc_flag` sets on the baud tick that ends the last stop bit, and only if the buffer is empty then.
- R7: `txc_flag` clears one cycle after a `txc_clr` or `irq_ack` pulse.
- R8: `irq` is high exactly when `txc_flag`, `txc_ie` and `gie` are all high.
- R9: Clearing `tx_en` keeps `txd_oe` high until the shifter and the buffer hold nothing more to send. After that `txd_oe` is low and `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| par_en | input | 1 | Insert parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| len_sel | input | 2 | Data length, 5 + value bits |
| two_stop | input | 1 | 1 = two stop bits |
| wr_data | input | 1 | Data write strobe |
| wdata | input | DW | Character to send |
| txc_clr | input | 1 | Write-one clear of the transmit-done flag |
| irq_ack | input | 1 | Interrupt acknowledge |
| txc_ie | input | 1 | Transmit-done interrupt enable |
| gie | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial data line |
| txd_oe | output | 1 | Line driver enable |
| buf_empty | output | 1 | Holding register is free |
| txc_flag | output | 1 | Transmit-done flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong frame layout shows on `txd` within the frame itself. It appears as a misplaced parity bit, a missing stop bit, or a start bit that comes one tick early or late. The sweep samples every bit position, so such a fault is caught on the first affected tick. A holding register that is overwritten, or that fails to hand over, shows up as the wrong character in the next frame or as an idle gap between queued frames. A stray transmit-done pulse shows as `txc_flag` or `irq` rising between back-to-back frames. A premature disable shows as `txd_oe` falling while bits are still pending.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int unsigned MIN_DATA = 5;
   localparam int unsigned MAX_DATA = 8;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
   } sertx_cfg_t;
endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          accept_en,
   input  logic [DW-1:0] din,
   input  logic          take,
   output logic          full,
   output logic [DW-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_req && accept_en && !full) begin
         full <= 1'b1;
         dout <= din;
      end
   end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter bit          HAS_PARITY = 1'b1,
   parameter int unsigned FW         = 12,
   parameter int unsigned CW         = 4
) (
   input  logic [DW-1:0] data,
   input  sertx_cfg_t    cfg,
   output logic [FW-1:0] frame,
   output logic [CW-1:0] nbits
);
   logic par_on;
   logic par_sel_odd;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_on      = cfg.par_en;
         assign par_sel_odd = cfg.par_odd;
      end else begin : g_nopar
         assign par_on      = 1'b0;
         assign par_sel_odd = 1'b0;
      end
   endgenerate

   logic [CW-1:0] dlen;
   logic          ones;

   always_comb begin
      dlen = CW'(MIN_DATA) + CW'(cfg.len_sel);
      if (dlen > CW'(DW)) dlen = CW'(DW);
      ones     = 1'b0;
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < int'(DW); i++) begin
         if (CW'(i) < dlen) begin
            frame[i+1] = data[i];
            ones       = ones ^ data[i];
         end
      end
      if (par_on) frame[dlen + CW'(1)] = ones ^ par_sel_odd;
      nbits = CW'(1) + dlen + CW'(par_on) + (cfg.two_stop ? CW'(2) : CW'(1));
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int unsigned FW = 12,
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          avail,
   input  logic [FW-1:0] frame_in,
   input  logic [CW-1:0] nbits_in,
   output logic          take,
   output logic          fin_idle,
   output logic          busy,
   output logic          line
);
   logic [FW-1:0] sr;
   logic [CW-1:0] left;
   logic          last;
   logic          free;

   assign last     = (left == CW'(1));
   assign free     = !busy || last;
   assign take     = tick && free && avail;
   assign fin_idle = tick && busy && last && !avail;
   assign line     = sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '1;
         left <= '0;
         busy <= 1'b0;
      end else if (tick) begin
         if (free) begin
            if (avail) begin
               sr   <= frame_in;
               left <= nbits_in;
               busy <= 1'b1;
            end else begin
               sr   <= '1;
               left <= '0;
               busy <= 1'b0;
            end
         end else begin
            sr   <= {1'b1, sr[FW-1:1]};
            left <= left - CW'(1);
         end
      end
   end
endmodule

// File: rtl/sertx_status.sv
module sertx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_txc,
   input  logic clr_w1,
   input  logic ack,
   input  logic ie,
   input  logic gie,
   input  logic en,
   input  logic busy,
   input  logic full,
   output logic txc,
   output logic irq,
   output logic oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              txc <= 1'b0;
      else if (set_txc)        txc <= 1'b1;
      else if (clr_w1 || ack)  txc <= 1'b0;
   end

   assign irq = txc && ie && gie;
   assign oe  = en || busy || full;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          tx_en,
   input  logic          par_en,
   input  logic          par_odd,
   input  logic [1:0]    len_sel,
   input  logic          two_stop,
   input  logic          wr_data,
   input  logic [DW-1:0] wdata,
   input  logic          txc_clr,
   input  logic          irq_ack,
   input  logic          txc_ie,
   input  logic          gie,
   output logic          txd,
   output logic          txd_oe,
   output logic          buf_empty,
   output logic          txc_flag,
   output logic          irq
);
   localparam int unsigned FW = 1 + DW + 1 + 2;
   localparam int unsigned CW = $clog2(FW + 1);

   generate
      if (DW < MIN_DATA || DW > MAX_DATA) begin : g_bad_dw
         $error("sertx_top: DW out of range");
      end
   endgenerate

   sertx_cfg_t    cfg;
   logic          full;
   logic [DW-1:0] held;
   logic [FW-1:0] frame;
   logic [CW-1:0] nbits;
   logic          take;
   logic          fin_idle;
   logic          busy;
   logic          line;

   assign cfg = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

   sertx_holdreg #(.DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_data), .accept_en(tx_en),
      .din(wdata), .take(take), .full(full), .dout(held)
   );

   sertx_framer #(.DW(DW), .HAS_PARITY(HAS_PARITY), .FW(FW), .CW(CW)) u_frm (
      .data(held), .cfg(cfg), .frame(frame), .nbits(nbits)
   );

   sertx_shifter #(.FW(FW), .CW(CW)) u_shf (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .avail(full),
      .frame_in(frame), .nbits_in(nbits), .take(take), .fin_idle(fin_idle),
      .busy(busy), .line(line)
   );

   sertx_status u_st (
      .clk(clk), .rst_n(rst_n), .set_txc(fin_idle), .clr_w1(txc_clr),
      .ack(irq_ack), .ie(txc_ie), .gie(gie), .en(tx_en), .busy(busy),
      .full(full), .txc(txc_flag), .irq(irq), .oe(txd_oe)
   );

   assign txd       = txd_oe ? line : 1'b1;
   assign buf_empty = !full;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_en,
   input logic wr_data,
   input logic txc_clr,
   input logic irq_ack,
   input logic txd,
   input logic txd_oe,
   input logic buf_empty,
   input logic txc_flag
);
   // R4
   hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_empty && !baud_tick) |=> !buf_empty);

   // R4
   fill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_empty) |-> $past(wr_data && tx_en));

   // R6
   txc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txc_flag) |-> ($past(baud_tick) && buf_empty));

   // R7
   txc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txc_flag && (txc_clr || irq_ack) && !baud_tick) |=> !txc_flag);

   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !txd_oe |-> (txd && buf_empty));

   // R9
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txd_oe && !buf_empty) |=> txd_oe);
endmodule

bind sertx_top sertx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
   .wr_data(wr_data), .txc_clr(txc_clr), .irq_ack(irq_ack), .txd(txd),
   .txd_oe(txd_oe), .buf_empty(buf_empty), .txc_flag(txc_flag)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0, tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
   logic [1:0] len_sel = 2'd3;
   logic       two_stop = 1'b0, wr_data = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       txc_clr = 1'b0, irq_ack = 1'b0, txc_ie = 1'b0, gie = 1'b0;
   logic       txd, txd_oe, buf_empty, txc_flag, irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sertx_top u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
      .par_en(par_en), .par_odd(par_odd), .len_sel(len_sel), .two_stop(two_stop),
      .wr_data(wr_data), .wdata(wdata), .txc_clr(txc_clr), .irq_ack(irq_ack),
      .txc_ie(txc_ie), .gie(gie), .txd(txd), .txd_oe(txd_oe),
      .buf_empty(buf_empty), .txc_flag(txc_flag), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic tick();
      baud_tick = 1'b1;
      cyc();
      baud_tick = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      wdata   = d;
      wr_data = 1'b1;
      cyc();
      wr_data = 1'b0;
   endtask

   function automatic int nbits_of(input int len, input int par, input int stop2);
      return 1 + len + par + (stop2 ? 2 : 1);
   endfunction

   function automatic int exp_bit(input logic [7:0] d, input int len, input int par,
                                  input int odd, input int k);
      int ones;
      ones = 0;
      for (int i = 0; i < len; i++) ones += d[i];
      if (k == 0) return 0;
      if (k <= len) return int'(d[k-1]);
      if (par != 0 && k == len + 1) return (ones + odd) % 2;
      return 1;
   endfunction

   // Checks one frame already started (start bit on the line now).
   task automatic check_frame(input string tag, input logic [7:0] d, input int len,
                              input int par, input int odd, input int stop2);
      int nb;
      nb = nbits_of(len, par, stop2);
      for (int k = 0; k < nb; k++) begin
         chk(tag, int'(txd), exp_bit(d, len, par, odd, k));
         if (k > 0) chk("R6 no early flag", int'(txc_flag), 0);
         tick();
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      // reset state
      chk("R9 reset txd", int'(txd), 1);
      chk("R9 reset oe", int'(txd_oe), 0);
      chk("R4 reset empty", int'(buf_empty), 1);
      chk("R6 reset txc", int'(txc_flag), 0);
      chk("R8 reset irq", int'(irq), 0);

      // R4: write while disabled is ignored
      wr(8'h5A);
      chk("R4 disabled write", int'(buf_empty), 1);
      chk("R9 disabled oe", int'(txd_oe), 0);

      // Sweep: R1 R2 R3 R5 R6 R7 R8
      tx_en  = 1'b1;
      txc_ie = 1'b1;
      for (int idx = 0; idx < 48; idx++) begin
         int len, par, odd, stop2;
         logic [7:0] d;
         len   = 5 + (idx / 12);
         par   = ((idx / 2) % 3) != 0 ? 1 : 0;
         odd   = ((idx / 2) % 3) == 2 ? 1 : 0;
         stop2 = idx % 2;
         d     = 8'(idx * 53 + 29);
         len_sel  = 2'(len - 5);
         par_en   = par[0];
         par_odd  = odd[0];
         two_stop = stop2[0];
         gie      = idx[2];
         wr(d);
         chk("R4 write fills", int'(buf_empty), 0);
         tick();
         chk("R5 transfer empties", int'(buf_empty), 1);
         check_frame("R1 R2 R3 frame bit", d, len, par, odd, stop2);
         chk("R6 done flag", int'(txc_flag), 1);
         chk("R1 idle high", int'(txd), 1);
         chk("R8 irq gating", int'(irq), int'(idx[2]));
         if (idx[0]) irq_ack = 1'b1; else txc_clr = 1'b1;
         cyc();
         irq_ack = 1'b0;
         txc_clr = 1'b0;
         chk("R7 flag cleared", int'(txc_flag), 0);
         chk("R8 irq after clear", int'(irq), 0);
      end

      // R4 + R5: write while full ignored, back-to-back frames
      len_sel = 2'd3; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0; gie = 1'b1;
      wr(8'hC3);
      wr(8'h18);
      chk("R4 full stays full", int'(buf_empty), 0);
      tick();
      wr(8'h7E);
      chk("R4 second write", int'(buf_empty), 0);
      check_frame("R4 kept char", 8'hC3, 8, 0, 0, 0);
      chk("R5 no gap start", int'(txd), 0);
      chk("R6 no flag when queued", int'(txc_flag), 0);
      chk("R5 handover empties", int'(buf_empty), 1);
      check_frame("R5 next char", 8'h7E, 8, 0, 0, 0);
      chk("R6 flag after pair", int'(txc_flag), 1);
      txc_clr = 1'b1; cyc(); txc_clr = 1'b0;

      // R9: disable drains pending data before release
      wr(8'h81);
      tick();
      wr(8'h42);
      tx_en = 1'b0;
      cyc();
      chk("R9 oe while draining", int'(txd_oe), 1);
      check_frame("R9 drain first", 8'h81, 8, 0, 0, 0);
      chk("R9 oe still on", int'(txd_oe), 1);
      check_frame("R9 drain second", 8'h42, 8, 0, 0, 0);
      chk("R9 released", int'(txd_oe), 0);
      chk("R9 line high", int'(txd), 1);
      chk("R6 flag after drain", int'(txc_flag), 1);
      irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
      chk("R7 ack clears", int'(txc_flag), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule